// File: doc/BRIEF.md
# Three-Wire Configuration Slave

This block takes a slow three-wire serial configuration bus (a data wire, a clock wire and an active-low frame enable) into the system clock domain. It collects a 16-bit frame and writes it into one of three 14-bit configuration words. The two leading bits of the frame pick the target word. The frame takes effect when the enable wire returns high, and only if exactly sixteen serial clock rising edges were seen while the enable was low.

From those configuration words the block derives the device control signals: chip enable, receive or transmit activity, an oscillator-run request and the transmit data bit. A mode bit in the first word picks the source of these signals. When it is clear they follow external pins. When it is set they follow bits of the first and third words, and the pins have no effect. The bus stays writable at all times, including while the device is disabled.

Top module: `cfg3w_top`

## Requirements
- R1: After reset, word A = 14'h0010, word B = 14'h0000 and word C = 14'h1520.
- R2: A frame is 16 bits, MSB first, and each bit is taken on a rising serial clock edge while the enable wire is low. On the enable rising edge, frame bits [15:14] pick the target (00 = A, 01 = B, 10 = C), and frame bits [13:0] replace that word.
- R3: A frame whose bits [15:14] are 11 changes no word.
- R4: A frame that ends after 15 or after 17 serial clock edges since the enable fell changes no word.
- R5: When A[13] = 0, dev_en equals pin_en. While dev_en is 1, pin_rxtx = 1 selects receive (rx_on = 1, tx_on = 0) and pin_rxtx = 0 selects transmit (tx_on = 1, rx_on = 0).
- R6: While the effective enable is 0, rx_on and tx_on are both 0, whatever the mode source holds.
- R7: When A[13] = 1, dev_en equals A[11]. The mode comes from A[10] (1 = receive, 0 = transmit). pin_en and pin_rxtx have no effect.
- R8: clk_run = A[12] OR the effective enable.
- R9: tx_data equals C[7] when A[13] = 1 and equals pin_txd when A[13] = 0.
- R10: Frames are accepted while the device is disabled.
- R11: Serial clock edges that occur while the enable wire is high do not change any word or disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk | input | 1 | Serial clock, asynchronous to clk |
| bus_dat | input | 1 | Serial data |
| bus_en_n | input | 1 | Frame enable, active low; its rising edge commits the frame |
| pin_en | input | 1 | External chip enable |
| pin_rxtx | input | 1 | External mode select, 1 = receive |
| pin_txd | input | 1 | External transmit data |
| word_a | output | 14 | Configuration word A |
| word_b | output | 14 | Configuration word B |
| word_c | output | 14 | Configuration word C |
| dev_en | output | 1 | Effective chip enable |
| rx_on | output | 1 | Receiver active |
| tx_on | output | 1 | Transmitter active |
| clk_run | output | 1 | Oscillator run request |
| tx_data | output | 1 | Effective transmit data bit |

## Verification
Any of these faults shows up at the ports within a few system clocks of the enable rising edge: a bit counter that is off by one, a shift register that is misaligned, or a header that is decoded wrongly. In each case the wrong word changes, or a word takes a shifted value, or a frame that should be rejected is accepted. A wrong mode source shows on dev_en, rx_on, tx_on, clk_run or tx_data in the same cycle the offending word or pin changes. Pin toggling while register control is active exposes any leakage at once.

// File: rtl/cfg3w_pkg.sv
// Shared constants and types for the three-wire configuration slave.
// Assumes a 16-bit frame made of a 2-bit header and a 14-bit payload.
package cfg3w_pkg;
    localparam int FRAME_BITS = 16;
    localparam int WORD_BITS  = 14;
    localparam int HDR_BITS   = FRAME_BITS - WORD_BITS;

    typedef enum logic [HDR_BITS-1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_C    = 2'b10,
        SEL_NONE = 2'b11
    } sel_e;

    localparam logic [WORD_BITS-1:0] RST_A = 14'h0010;
    localparam logic [WORD_BITS-1:0] RST_B = 14'h0000;
    localparam logic [WORD_BITS-1:0] RST_C = 14'h1520;

    // Bit positions inside the configuration words
    localparam int A_REGCTL = 13;
    localparam int A_CLKRUN = 12;
    localparam int A_ENABLE = 11;
    localparam int A_RXMODE = 10;
    localparam int C_TXBIT  = 7;
endpackage

// File: rtl/cfg3w_sync.sv
// Multi-stage level synchronizer for a vector of asynchronous inputs.
// Assumes each bit is a slow level that changes far less often than clk.
module cfg3w_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // Shift the inputs through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg3w_shifter.sv
// Frame collector: shifts serial bits on serial clock rising edges while the
// enable is low and counts them. On the enable rising edge it emits one
// valid pulse, but only if exactly FRAME_BITS bits were counted.
// Assumes synchronized inputs that are aligned with each other.
module cfg3w_shifter
    import cfg3w_pkg::*;
#(
    parameter int NBITS = FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_clk,
    input  logic             s_dat,
    input  logic             s_en_n,
    output logic             frm_vld,
    output logic [NBITS-1:0] frm_word
);
    localparam int CNT_MAX = NBITS + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic          clk_d, en_d;
    logic          clk_rise, en_rise, en_fall;
    logic [NBITS-1:0] sh;
    logic [CW-1:0] cnt;

    // Remember previous levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d <= 1'b0;
            en_d  <= 1'b1;
        end else begin
            clk_d <= s_clk;
            en_d  <= s_en_n;
        end
    end

    assign clk_rise = s_clk & ~clk_d;
    assign en_rise  = s_en_n & ~en_d;
    assign en_fall  = ~s_en_n & en_d;

    // Shift in data bits and count them, saturating past a full frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (en_fall) begin
            cnt <= '0;
        end else if (clk_rise && !s_en_n) begin
            sh <= {sh[NBITS-2:0], s_dat};
            if (cnt != CW'(CNT_MAX)) cnt <= cnt + 1'b1;
        end
    end

    // Commit pulse on enable rise with an exact-length frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_vld  <= 1'b0;
            frm_word <= '0;
        end else begin
            frm_vld  <= en_rise && (cnt == CW'(NBITS));
            frm_word <= sh;
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(CNT_MAX));
    // R4
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> (cnt == '0));
endmodule

// File: rtl/cfg3w_regfile.sv
// Three configuration words with reset defaults. A valid frame writes its
// payload into the word named by its header; header SEL_NONE is dropped.
// Assumes frm_vld is a single-cycle pulse.
module cfg3w_regfile
    import cfg3w_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frm_vld,
    input  logic [FRAME_BITS-1:0] frm_word,
    output logic [WORD_BITS-1:0]  word_a,
    output logic [WORD_BITS-1:0]  word_b,
    output logic [WORD_BITS-1:0]  word_c
);
    sel_e                 sel;
    logic [WORD_BITS-1:0] pay;

    assign sel = sel_e'(frm_word[FRAME_BITS-1 -: HDR_BITS]);
    assign pay = frm_word[WORD_BITS-1:0];

    // Load the addressed word on a valid frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_a <= RST_A;
            word_b <= RST_B;
            word_c <= RST_C;
        end else if (frm_vld) begin
            case (sel)
                SEL_A:   word_a <= pay;
                SEL_B:   word_b <= pay;
                SEL_C:   word_c <= pay;
                default: ;
            endcase
        end
    end

    // R3
    drop_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && sel == SEL_NONE) |=>
            ($stable(word_a) && $stable(word_b) && $stable(word_c)));
    // R2
    load_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && sel == SEL_B) |=> (word_b == $past(pay)) && $stable(word_a));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld |=> ($stable(word_a) && $stable(word_b) && $stable(word_c)));
endmodule

// File: rtl/cfg3w_ctrl.sv
// Derives the device control signals from word A, word C and the pins.
// Purely combinational; assumes the words are stable register outputs.
module cfg3w_ctrl
    import cfg3w_pkg::*;
(
    input  logic [WORD_BITS-1:0] word_a,
    input  logic [WORD_BITS-1:0] word_c,
    input  logic                 pin_en,
    input  logic                 pin_rxtx,
    input  logic                 pin_txd,
    output logic                 dev_en,
    output logic                 rx_on,
    output logic                 tx_on,
    output logic                 clk_run,
    output logic                 tx_data
);
    logic reg_ctl, rx_sel;

    // Select the control source and gate the mode with the enable
    always_comb begin
        reg_ctl = word_a[A_REGCTL];
        dev_en  = reg_ctl ? word_a[A_ENABLE] : pin_en;
        rx_sel  = reg_ctl ? word_a[A_RXMODE] : pin_rxtx;
        rx_on   = dev_en & rx_sel;
        tx_on   = dev_en & ~rx_sel;
        clk_run = word_a[A_CLKRUN] | dev_en;
        tx_data = reg_ctl ? word_c[C_TXBIT] : pin_txd;
    end
endmodule

// File: rtl/cfg3w_top.sv
// Three-wire configuration slave: synchronizes the bus, collects frames,
// stores three configuration words and derives device control outputs.
// Assumes the serial clock runs well below a quarter of clk.
module cfg3w_top
    import cfg3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_clk,
    input  logic                 bus_dat,
    input  logic                 bus_en_n,
    input  logic                 pin_en,
    input  logic                 pin_rxtx,
    input  logic                 pin_txd,
    output logic [WORD_BITS-1:0] word_a,
    output logic [WORD_BITS-1:0] word_b,
    output logic [WORD_BITS-1:0] word_c,
    output logic                 dev_en,
    output logic                 rx_on,
    output logic                 tx_on,
    output logic                 clk_run,
    output logic                 tx_data
);
    logic [2:0]            bus_s;
    logic                  frm_vld;
    logic [FRAME_BITS-1:0] frm_word;

    cfg3w_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
        .clk (clk), .rst_n (rst_n),
        .d   ({bus_en_n, bus_clk, bus_dat}),
        .q   (bus_s)
    );

    cfg3w_shifter #(.NBITS(FRAME_BITS)) u_shift (
        .clk (clk), .rst_n (rst_n),
        .s_clk (bus_s[1]), .s_dat (bus_s[0]), .s_en_n (bus_s[2]),
        .frm_vld (frm_vld), .frm_word (frm_word)
    );

    cfg3w_regfile u_regs (
        .clk (clk), .rst_n (rst_n),
        .frm_vld (frm_vld), .frm_word (frm_word),
        .word_a (word_a), .word_b (word_b), .word_c (word_c)
    );

    cfg3w_ctrl u_ctrl (
        .word_a (word_a), .word_c (word_c),
        .pin_en (pin_en), .pin_rxtx (pin_rxtx), .pin_txd (pin_txd),
        .dev_en (dev_en), .rx_on (rx_on), .tx_on (tx_on),
        .clk_run (clk_run), .tx_data (tx_data)
    );

    // R6
    mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_on, tx_on}) && ((rx_on || tx_on) == dev_en));
    // R8
    run_on_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_en |-> clk_run);
    // R7
    pin_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_a[A_REGCTL] && $stable(word_a)) |-> ($stable(dev_en) && $stable(rx_on)));
endmodule

// File: tb/sim_cfg3w_top.sv
module sim_cfg3w_top;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 4;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_clk = 1'b0, bus_dat = 1'b0, bus_en_n = 1'b1;
    logic pin_en = 1'b0, pin_rxtx = 1'b0, pin_txd = 1'b0;
    logic [13:0] word_a, word_b, word_c;
    logic dev_en, rx_on, tx_on, clk_run, tx_data;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [13:0] ea = 14'h0010, eb = 14'h0000, ec = 14'h1520;

    cfg3w_top u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_words(input string req);
        chk(req, 32'(word_a), 32'(ea));
        chk(req, 32'(word_b), 32'(eb));
        chk(req, 32'(word_c), 32'(ec));
    endtask

    // Send the n low bits of w, MSB first, then raise the enable
    task automatic send(input logic [31:0] w, input int n);
        bus_en_n = 1'b0; wclk(HB);
        for (int i = n - 1; i >= 0; i--) begin
            bus_dat = w[i]; wclk(HB);
            bus_clk = 1'b1; wclk(HB);
            bus_clk = 1'b0;
        end
        wclk(HB);
        bus_en_n = 1'b1; wclk(10);
    endtask

    task automatic t_reset;
        check_words("R1");
        chk("R5", 32'({dev_en, rx_on, tx_on}), 0);
        chk("R8", 32'(clk_run), 0);
    endtask

    task automatic t_write;
        // R10: device is disabled (pin_en = 0) during these frames
        send(32'h0012, 16); ea = 14'h0012; check_words("R2 R10");
        send(32'h6A5C, 16); eb = 14'h2A5C; check_words("R2");
        send(32'h8BCD, 16); ec = 14'h0BCD; check_words("R2");
    endtask

    task automatic t_discard;
        send(32'hFFFF, 16); check_words("R3");
        send(32'h4123, 15); check_words("R4 short");
        send(32'h04123, 17); check_words("R4 long");
    endtask

    task automatic t_idle_clocks;
        // R11: clocks with enable high, then a normal frame
        for (int i = 0; i < 5; i++) begin
            bus_dat = 1'b1; bus_clk = 1'b1; wclk(HB); bus_clk = 1'b0; wclk(HB);
        end
        check_words("R11");
        send(32'h4055, 16); eb = 14'h0055; check_words("R11");
    endtask

    task automatic t_pins;
        pin_en = 1'b1; pin_rxtx = 1'b1; pin_txd = 1'b1; wclk(2);
        chk("R5 rx", 32'({dev_en, rx_on, tx_on}), 32'b110);
        chk("R9 pin", 32'(tx_data), 1);
        chk("R8", 32'(clk_run), 1);
        pin_rxtx = 1'b0; pin_txd = 1'b0; wclk(2);
        chk("R5 tx", 32'({dev_en, rx_on, tx_on}), 32'b101);
        chk("R9 pin", 32'(tx_data), 0);
        pin_en = 1'b0; pin_rxtx = 1'b1; wclk(2);
        chk("R6", 32'({dev_en, rx_on, tx_on}), 0);
        chk("R8", 32'(clk_run), 0);
    endtask

    task automatic t_regctl;
        send(32'h2C00, 16); ea = 14'h2C00;   // ctl=1 en=1 rx=1
        check_words("R7");
        chk("R7 rx", 32'({dev_en, rx_on, tx_on}), 32'b110);
        chk("R9 reg", 32'(tx_data), 1);      // C[7] of 0x0BCD is 1
        pin_en = 1'b0; pin_rxtx = 1'b0; pin_txd = 1'b0; wclk(2);
        chk("R7 pins ignored", 32'({dev_en, rx_on, tx_on}), 32'b110);
        chk("R9 pin ignored", 32'(tx_data), 1);
        send(32'h2800, 16); ea = 14'h2800;   // en=1 tx
        pin_rxtx = 1'b1; pin_en = 1'b1; wclk(2);
        chk("R7 tx", 32'({dev_en, rx_on, tx_on}), 32'b101);
        send(32'h2400, 16); ea = 14'h2400;   // en=0 rx bit set
        chk("R6 reg", 32'({dev_en, rx_on, tx_on}), 0);
        chk("R8 off", 32'(clk_run), 0);
        send(32'h3000, 16); ea = 14'h3000;   // clock forced, disabled
        chk("R8 forced", 32'({clk_run, dev_en}), 32'b10);
        send(32'h8B4D, 16); ec = 14'h0B4D;   // C[7] = 0
        chk("R9 reg", 32'(tx_data), 0);
        send(32'h0010, 16); ea = 14'h0010;
        wclk(2);
        chk("R5 back", 32'({dev_en, rx_on, tx_on}), 32'b110);
        check_words("R2");
    endtask

    initial begin
        wclk(4);
        rst_n = 1'b1;
        wclk(4);
        t_reset();
        t_write();
        t_discard();
        t_idle_clocks();
        t_pins();
        t_regctl();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule